// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This block sits between a host's active-low memory chip-enable and a battery-backed low-power SRAM. It drives a conditioned chip-enable toward the memory. While supply is good, the conditioned enable follows the host. When a digital power-fail flag from an external comparator rises, the memory is shut off. An access that is already under way may finish first, but only for a bounded number of cycles.

Once protection is in force it holds until the flag clears. A fixed recovery period in clock cycles must then elapse. The gate then waits for the host enable to be idle, so that a fresh access never starts halfway through a cycle. Reset is handled as a power-up and opens with the recovery period. The power-fail flag is brought into the clock domain through two flip-flops. A status output reports when the memory is being held off.

Top module: `pf_ce_guard`

## Requirements
- R1: While protection is off and no failure is pending, `mem_ce_n` equals `host_ce_n` in the same cycle, with no register in the path.
- R2: With `host_ce_n` high, a rise of `pwr_fail` sets `wr_prot` high and holds `mem_ce_n` high starting at the third rising clock edge after the change. Two of those edges are the synchronizer.
- R3: If `host_ce_n` is low when the synchronized failure is seen, `mem_ce_n` stays low until the host raises `host_ce_n`. Protection starts at the next edge after that.
- R4: A deferred access lasts at most `DEFER_CYCLES` cycles after the failure is seen. After that, `mem_ce_n` is forced high even if `host_ce_n` is still low.
- R5: While the synchronized failure flag stays high, protection stays in force. A new low on `host_ce_n` leaves `mem_ce_n` high.
- R6: After the synchronized flag clears, `wr_prot` and `mem_ce_n` stay high for `RECOVER_CYCLES`+1 cycles when the host is idle. Counted from the falling edge of `pwr_fail`, protection ends at edge `RECOVER_CYCLES`+4.
- R7: If `host_ce_n` is low when the recovery period ends, protection holds. The gate opens only at the edge after `host_ce_n` goes high.
- R8: During and after reset, `mem_ce_n` and `wr_prot` are high. After reset is released, a full recovery period runs: `wr_prot` falls at the `RECOVER_CYCLES`+1-th edge.
- R9: A failure seen during recovery returns the gate to protection. When the flag clears again, the recovery count restarts from zero.
- R10: `wr_prot` is high exactly while the gate holds `mem_ce_n` high by force, so `wr_prot` high always implies `mem_ce_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; behaves as a power-up |
| host_ce_n | input | 1 | Host chip-enable, active low |
| pwr_fail | input | 1 | Power-fail flag from the comparator, asynchronous, active high |
| mem_ce_n | output | 1 | Conditioned chip-enable to the memory, active low |
| wr_prot | output | 1 | High while the memory is held off |

## Verification
The assertions check, on every cycle, the relations that hold at any single moment:
- pass-through whenever the gate is open;
- a forced-high enable whenever protection is reported;
- the bound on the deferral length;
- that protection holds while the flag is up;
- the fall back to protection from recovery;
- that the gate opens only after a cycle in which the host was idle and a full recovery count had run.

Only the bench scenarios show the exact latencies: the three-edge detection delay, the recovery length measured from the flag edge and from reset, and the restart of the count after a glitch during recovery. The bench sweeps the length of the in-flight access across both sides of the deferral limit and checks every cycle of each run.

// File: rtl/pf_ce_guard.sv
module pf_ce_guard #(
  parameter int unsigned DEFER_CYCLES   = 16,
  parameter int unsigned RECOVER_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_ce_n,
  input  logic pwr_fail,
  output logic mem_ce_n,
  output logic wr_prot
);
  localparam int unsigned CNT_TOP = (DEFER_CYCLES > RECOVER_CYCLES) ? DEFER_CYCLES : RECOVER_CYCLES;
  localparam int unsigned CW      = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] DEF_LAST = CW'(DEFER_CYCLES - 1);
  localparam logic [CW-1:0] REC_END  = CW'(RECOVER_CYCLES);

  typedef enum logic [1:0] {ST_NORMAL, ST_DEFER, ST_PROTECT, ST_RECOVER} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          pf_meta, pf_sync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_meta <= 1'b0;
      pf_sync <= 1'b0;
    end else begin
      pf_meta <= pwr_fail;
      pf_sync <= pf_meta;
    end

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      ST_NORMAL:
        if (pf_sync) begin
          cnt_nx = '0;
          st_nx  = host_ce_n ? ST_PROTECT : ST_DEFER;
        end
      ST_DEFER:
        if (host_ce_n || cnt == DEF_LAST) st_nx = ST_PROTECT;
        else cnt_nx = cnt + 1'b1;
      ST_PROTECT:
        if (!pf_sync) begin
          st_nx  = ST_RECOVER;
          cnt_nx = '0;
        end
      ST_RECOVER:
        if (pf_sync) st_nx = ST_PROTECT;
        else if (cnt != REC_END) cnt_nx = cnt + 1'b1;
        else if (host_ce_n) st_nx = ST_NORMAL;
      default: st_nx = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_RECOVER;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  wire gate_open = (st == ST_NORMAL) || (st == ST_DEFER);
  assign mem_ce_n = gate_open ? host_ce_n : 1'b1;
  assign wr_prot  = !gate_open;
endmodule

// File: rtl/pf_ce_guard_chk.sv
module pf_ce_guard_chk #(
  parameter int unsigned DEFER_CYCLES   = 16,
  parameter int unsigned RECOVER_CYCLES = 10_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ce_n,
  input logic       mem_ce_n,
  input logic       wr_prot,
  input logic [1:0] st,
  input logic       pf_sync
);
  localparam logic [1:0] S_DEFER   = 2'd1;
  localparam logic [1:0] S_PROTECT = 2'd2;
  localparam logic [1:0] S_RECOVER = 2'd3;

  int unsigned def_run, rec_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      def_run <= 0;
      rec_run <= 0;
    end else begin
      def_run <= (st == S_DEFER)   ? def_run + 1 : 0;
      rec_run <= (st == S_RECOVER) ? rec_run + 1 : 0;
    end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_prot |-> (mem_ce_n == host_ce_n));
  assert_defer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    def_run <= DEFER_CYCLES);
  assert_hold_while_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_prot && pf_sync) |=> wr_prot);
  assert_recover_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_prot) |-> (rec_run >= RECOVER_CYCLES + 1));
  assert_open_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_prot) |-> $past(host_ce_n));
  assert_refail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECOVER && pf_sync) |=> (st == S_PROTECT));
  assert_prot_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prot |-> mem_ce_n);
endmodule

bind pf_ce_guard pf_ce_guard_chk #(
  .DEFER_CYCLES(DEFER_CYCLES),
  .RECOVER_CYCLES(RECOVER_CYCLES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .host_ce_n(host_ce_n),
  .mem_ce_n(mem_ce_n),
  .wr_prot(wr_prot),
  .st(st),
  .pf_sync(pf_sync)
);

// File: tb/pf_ce_guard_bench.sv
module pf_ce_guard_bench;
  localparam int unsigned DEF = 4;
  localparam int unsigned REC = 6;

  logic clk = 1'b0, rst_n = 1'b0, host_ce_n = 1'b1, pwr_fail = 1'b0;
  logic mem_ce_n, wr_prot;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pf_ce_guard #(.DEFER_CYCLES(DEF), .RECOVER_CYCLES(REC)) u_pf_ce_guard (
    .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .pwr_fail(pwr_fail),
    .mem_ce_n(mem_ce_n), .wr_prot(wr_prot));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic check_n(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic count_prot(output int n);
    n = 0;
    while (wr_prot === 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R8 reset ce", mem_ce_n, 1'b1);
    check("R8 reset prot", wr_prot, 1'b1);
    rst_n = 1'b1;
    count_prot(n);
    check_n("R8 recovery after reset", n, REC + 1);

    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      host_ce_n = i[0] ^ i[2] ^ (i[4] & i[1]);
      #1;
      check("R1 pass-through", mem_ce_n, host_ce_n);
      check("R1 open", wr_prot, 1'b0);
    end
    @(negedge clk);
    host_ce_n = 1'b1;

    for (int L = 1; L <= int'(DEF) + 5; L++) begin
      int pe;
      pe = (L + 1 < 3 + int'(DEF)) ? L + 1 : 3 + int'(DEF);
      if (pe < 3) pe = 3;
      @(negedge clk);
      host_ce_n = 1'b0;
      pwr_fail  = 1'b1;
      for (int j = 1; j <= L + int'(DEF) + 6; j++) begin
        @(negedge clk);
        if (j < pe && j <= L)           check("R3 access continues", mem_ce_n, 1'b0);
        else if (j > L + 2)             check("R5 no re-enable", mem_ce_n, 1'b1);
        else if (j >= 3 + int'(DEF))    check("R4 timeout forces high", mem_ce_n, 1'b1);
        else                            check("R2 forced high", mem_ce_n, 1'b1);
        check("R10 status", wr_prot, j >= pe);
        if (j == L) host_ce_n = 1'b1;
        if (j == L + 2) host_ce_n = 1'b0;
      end
      if (L % 2 == 1) begin
        pwr_fail = 1'b0;
        for (int k = 1; k <= int'(REC) + 8; k++) begin
          @(negedge clk);
          check("R7 hold while host active", wr_prot, 1'b1);
          check("R7 ce held", mem_ce_n, 1'b1);
        end
        host_ce_n = 1'b1;
        @(negedge clk);
        check("R7 opens after idle", wr_prot, 1'b0);
      end else begin
        host_ce_n = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b0;
        count_prot(n);
        check_n("R6 recovery length", n, REC + 4);
      end
    end

    @(negedge clk);
    pwr_fail = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 protected", wr_prot, 1'b1);
    pwr_fail = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 in recovery", wr_prot, 1'b1);
    pwr_fail = 1'b1;
    repeat (2) @(negedge clk);
    pwr_fail = 1'b0;
    count_prot(n);
    check_n("R9 recovery restarts", n, REC + 4);
    @(negedge clk);
    host_ce_n = 1'b0;
    #1;
    check("R1 open after restart", mem_ce_n, 1'b0);
    finish_run();
  end
endmodule